// File: doc/BRIEF.md
# Calendar Real-Time Clock with Staged Commit

This block keeps calendar time in seven fields: second, minute, hour, day of month, weekday, month and year. A one-cycle tick enable at 1 Hz advances the time. The block also holds a second set of the same seven fields as an alarm. A 16-bit register bus reaches every field, the interrupt enable and status bits, a per-field alarm mask and a latched wake flag.

Writes to time or alarm fields go into shadow registers and have no effect on the running clock or the comparator. A write of 1 to the commit register starts a two-cycle transfer, and a busy flag can be polled during it. At the end of the transfer, every shadow block written since the previous commit is copied into the live registers in a single clock edge, so no tick can land between two field updates.

An alarm fires when the live time becomes equal to the live alarm on every field that is not masked. It raises a level interrupt and latches a wake request. In one-shot mode the alarm disarms itself as it fires.

Top module: `cal_rtc`

## Requirements
- R1: After reset, the live time reads second 0, minute 0, hour 0, day 1, weekday 1, month 1 and year 0. The alarm fields, status, enable, mask, busy and wake all read 0, and `alarm_irq` and `wake_req` are low.
- R2: Byte addresses 0x0A to 0x16 map to the seven time fields and 0x18 to 0x24 map to the seven alarm fields, in steps of two and in the order second, minute, hour, day, weekday, month, year. Reads at these addresses return live values. A write lands only in the shadow copy and leaves the live value unchanged until a commit.
- R3: A write of 1 in bit 0 to byte address 0x3C sets bit 6 of address 0x00 (busy) for exactly two cycles. The shadowed values become live at the edge where busy clears.
- R4: A commit copies only the blocks (time, alarm) that have been written since the last commit. An unwritten block keeps its live value.
- R5: On each tick, the second wraps from 59 to 0 and carries into the minute. The minute wraps from 59 to 0 and carries into the hour. The hour wraps from 23 to 0. At each day rollover the weekday goes from 7 to 1 and otherwise increments.
- R6: The day of month rolls over after the last day of the month: February has 29 days when the year field is a multiple of 4 and 28 otherwise, and April, June, September and November have 30. Month 12 rolls to 1 and increments the year, which wraps from 127 to 0.
- R7: An alarm event occurs on the cycle after the live time first equals the live alarm on all fields whose bit in the mask at 0x08 is 0 (bit i masks field i in the R2 order). If enable bit 0 at 0x04 is set, the event sets status bit 0 at 0x02 and pending bit 4 at 0x2E.
- R8: `alarm_irq` is high exactly while status bit 0 is set. A bus read of address 0x02 clears that bit.
- R9: With enable bit 2 (one-shot) set, an alarm event that sets the status also clears enable bit 0.
- R10: With enable bit 0 clear, an alarm event changes neither the status nor the pending bit.
- R11: Writing 0 to bit 4 at 0x2E clears the pending bit. `wake_req` follows the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address (even) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| alarm_irq | output | 1 | Level alarm interrupt |
| wake_req | output | 1 | Latched wake request |

## Verification
The counter is driven from four starting points. A year-end second shows that every carry and the weekday wrap fire together. February 28 in a leap year and in a common year must give different results. An alarm-only commit must leave the running time untouched, which separates per-block commit from a full reload. The comparator is then tried in continuous, one-shot, disabled and weekday-unmasked configurations against the same time pattern, so that each enable and mask bit is the only difference between a firing and a silent alarm.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int unsigned NFIELD = 7;

  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_STS  = 6'h02;
  localparam logic [5:0] A_EN   = 6'h04;
  localparam logic [5:0] A_MASK = 6'h08;
  localparam logic [5:0] A_TIME = 6'h0A;
  localparam logic [5:0] A_ALRM = 6'h18;
  localparam logic [5:0] A_PDN  = 6'h2E;
  localparam logic [5:0] A_TRIG = 6'h3C;
  localparam logic [5:0] T_END  = A_TIME + 6'(2 * NFIELD);
  localparam logic [5:0] L_END  = A_ALRM + 6'(2 * NFIELD);

  localparam int unsigned BUSY_BIT = 6;
  localparam int unsigned EN_AL    = 0;
  localparam int unsigned EN_ONE   = 2;
  localparam int unsigned PEND_BIT = 4;

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_DOM = 3'd3,
    F_DOW = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6
  } fld_e;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } cal_t;

  localparam cal_t TIME_RST = '{yr: 7'd0, mon: 4'd1, dow: 3'd1, dom: 5'd1,
                                hr: 5'd0, mn: 6'd0, sc: 6'd0};
  localparam cal_t ALRM_RST = '0;

  function automatic logic [7:0] get_fld(cal_t c, logic [2:0] i);
    logic [7:0] v;
    case (i)
      F_SEC:   v = {2'b0, c.sc};
      F_MIN:   v = {2'b0, c.mn};
      F_HOUR:  v = {3'b0, c.hr};
      F_DOM:   v = {3'b0, c.dom};
      F_DOW:   v = {5'b0, c.dow};
      F_MON:   v = {4'b0, c.mon};
      F_YEAR:  v = {1'b0, c.yr};
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic cal_t put_fld(cal_t c, logic [2:0] i, logic [15:0] v);
    cal_t r;
    r = c;
    case (i)
      F_SEC:   r.sc  = v[5:0];
      F_MIN:   r.mn  = v[5:0];
      F_HOUR:  r.hr  = v[4:0];
      F_DOM:   r.dom = v[4:0];
      F_DOW:   r.dow = v[2:0];
      F_MON:   r.mon = v[3:0];
      F_YEAR:  r.yr  = v[6:0];
      default: r = c;
    endcase
    return r;
  endfunction

  function automatic logic [4:0] month_days(logic [3:0] m, logic [6:0] y);
    logic [4:0] d;
    case (m)
      4'd2:                      d = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
      default:                   d = 5'd31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_rtc_count.sv
module cal_rtc_count
  import cal_rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  cal_t stg,
  output cal_t cur
);

  cal_t cur_q, cur_d;
  logic [4:0] last_day;

  assign last_day = month_days(cur_q.mon, cur_q.yr);

  always_comb begin
    cur_d = cur_q;
    if (load) begin
      cur_d = stg;
    end else if (tick) begin
      if (cur_q.sc >= 6'd59) begin
        cur_d.sc = 6'd0;
        if (cur_q.mn >= 6'd59) begin
          cur_d.mn = 6'd0;
          if (cur_q.hr >= 5'd23) begin
            cur_d.hr  = 5'd0;
            cur_d.dow = (cur_q.dow >= 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
            if (cur_q.dom >= last_day) begin
              cur_d.dom = 5'd1;
              if (cur_q.mon >= 4'd12) begin
                cur_d.mon = 4'd1;
                cur_d.yr  = cur_q.yr + 7'd1;
              end else begin
                cur_d.mon = cur_q.mon + 4'd1;
              end
            end else begin
              cur_d.dom = cur_q.dom + 5'd1;
            end
          end else begin
            cur_d.hr = cur_q.hr + 5'd1;
          end
        end else begin
          cur_d.mn = cur_q.mn + 6'd1;
        end
      end else begin
        cur_d.sc = cur_q.sc + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= TIME_RST;
    else        cur_q <= cur_d;
  end

  assign cur = cur_q;

endmodule

// File: rtl/cal_rtc_alarm.sv
module cal_rtc_alarm
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  cal_t              stg,
  input  cal_t              now,
  input  logic [NFIELD-1:0] mask,
  output cal_t              alarm,
  output logic              match_evt
);

  cal_t al_q, al_d;
  logic [NFIELD-1:0] fld_ok;
  logic match_now, match_q;

  assign al_d = load ? stg : al_q;

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign fld_ok[i] = mask[i] || (get_fld(now, 3'(i)) == get_fld(al_q, 3'(i)));
  end

  assign match_now = &fld_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q    <= ALRM_RST;
      match_q <= 1'b0;
    end else begin
      al_q    <= al_d;
      match_q <= match_now;
    end
  end

  assign match_evt = match_now & ~match_q;
  assign alarm     = al_q;

endmodule

// File: rtl/cal_rtc_regs.sv
module cal_rtc_regs
  import cal_rtc_pkg::*;
#(
  parameter int unsigned COMMIT_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  input  cal_t              live_time,
  input  cal_t              live_alarm,
  input  logic              match_evt,
  output logic [15:0]       bus_rdata,
  output cal_t              stg_time,
  output cal_t              stg_alarm,
  output logic              load_time,
  output logic              load_alarm,
  output logic              busy,
  output logic              en_al,
  output logic              oneshot,
  output logic              status,
  output logic              pending,
  output logic [NFIELD-1:0] mask
);

  localparam int unsigned CW = $clog2(COMMIT_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  cal_t st_q, st_d, sa_q, sa_d;
  logic tdirty_q, tdirty_d, adirty_q, adirty_d;
  logic en_q, en_d, one_q, one_d, sts_q, sts_d, pend_q, pend_d;
  logic [NFIELD-1:0] mask_q, mask_d;
  logic wr, rd, in_time, in_alrm, commit, fire;
  logic [2:0] tidx, aidx;

  assign wr      = bus_sel & bus_wr;
  assign rd      = bus_sel & ~bus_wr;
  assign in_time = (bus_addr >= A_TIME) && (bus_addr < T_END);
  assign in_alrm = (bus_addr >= A_ALRM) && (bus_addr < L_END);
  assign tidx    = 3'((bus_addr - A_TIME) >> 1);
  assign aidx    = 3'((bus_addr - A_ALRM) >> 1);
  assign busy    = (cnt_q != '0);
  assign commit  = (cnt_q == CW'(1));
  assign fire    = match_evt & en_q;

  always_comb begin
    cnt_d    = cnt_q;
    st_d     = st_q;
    sa_d     = sa_q;
    tdirty_d = tdirty_q;
    adirty_d = adirty_q;
    en_d     = en_q;
    one_d    = one_q;
    mask_d   = mask_q;
    sts_d    = sts_q;
    pend_d   = pend_q;

    if (busy) cnt_d = cnt_q - CW'(1);
    else if (wr && bus_addr == A_TRIG && bus_wdata[0]) cnt_d = CW'(COMMIT_CYCLES);

    if (commit) begin
      tdirty_d = 1'b0;
      adirty_d = 1'b0;
    end
    if (wr && in_time) begin
      st_d     = put_fld(st_q, tidx, bus_wdata);
      tdirty_d = 1'b1;
    end
    if (wr && in_alrm) begin
      sa_d     = put_fld(sa_q, aidx, bus_wdata);
      adirty_d = 1'b1;
    end

    if (wr && bus_addr == A_EN) begin
      en_d  = bus_wdata[EN_AL];
      one_d = bus_wdata[EN_ONE];
    end
    if (fire && one_q) en_d = 1'b0;

    if (wr && bus_addr == A_MASK) mask_d = bus_wdata[NFIELD-1:0];

    if (rd && bus_addr == A_STS) sts_d = 1'b0;
    if (fire) sts_d = 1'b1;

    if (wr && bus_addr == A_PDN) pend_d = bus_wdata[PEND_BIT];
    if (fire) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      st_q     <= TIME_RST;
      sa_q     <= ALRM_RST;
      tdirty_q <= 1'b0;
      adirty_q <= 1'b0;
      en_q     <= 1'b0;
      one_q    <= 1'b0;
      mask_q   <= '0;
      sts_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      st_q     <= st_d;
      sa_q     <= sa_d;
      tdirty_q <= tdirty_d;
      adirty_q <= adirty_d;
      en_q     <= en_d;
      one_q    <= one_d;
      mask_q   <= mask_d;
      sts_q    <= sts_d;
      pend_q   <= pend_d;
    end
  end

  always_comb begin
    bus_rdata = 16'h0000;
    if (bus_addr == A_CTRL)      bus_rdata[BUSY_BIT] = busy;
    else if (bus_addr == A_STS)  bus_rdata[0] = sts_q;
    else if (bus_addr == A_EN) begin
      bus_rdata[EN_AL]  = en_q;
      bus_rdata[EN_ONE] = one_q;
    end
    else if (bus_addr == A_MASK) bus_rdata[NFIELD-1:0] = mask_q;
    else if (bus_addr == A_PDN)  bus_rdata[PEND_BIT] = pend_q;
    else if (in_time)            bus_rdata = {8'h00, get_fld(live_time, tidx)};
    else if (in_alrm)            bus_rdata = {8'h00, get_fld(live_alarm, aidx)};
  end

  assign stg_time   = st_q;
  assign stg_alarm  = sa_q;
  assign load_time  = commit & tdirty_q;
  assign load_alarm = commit & adirty_q;
  assign en_al      = en_q;
  assign oneshot    = one_q;
  assign status     = sts_q;
  assign pending    = pend_q;
  assign mask       = mask_q;

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int unsigned COMMIT_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        alarm_irq,
  output logic        wake_req
);

  logic [1:0] rst_sync_q;
  logic rst_ns;
  cal_t stg_time, stg_alarm, tm_live, al_live;
  logic load_time, load_alarm, busy, en_al, oneshot, status, pending, match_evt;
  logic [NFIELD-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  cal_rtc_regs #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .live_time  (tm_live),
    .live_alarm (al_live),
    .match_evt  (match_evt),
    .bus_rdata  (bus_rdata),
    .stg_time   (stg_time),
    .stg_alarm  (stg_alarm),
    .load_time  (load_time),
    .load_alarm (load_alarm),
    .busy       (busy),
    .en_al      (en_al),
    .oneshot    (oneshot),
    .status     (status),
    .pending    (pending),
    .mask       (mask)
  );

  cal_rtc_count u_count (
    .clk   (clk),
    .rst_n (rst_ns),
    .tick  (tick_1hz),
    .load  (load_time),
    .stg   (stg_time),
    .cur   (tm_live)
  );

  cal_rtc_alarm u_alarm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load      (load_alarm),
    .stg       (stg_alarm),
    .now       (tm_live),
    .mask      (mask),
    .alarm     (al_live),
    .match_evt (match_evt)
  );

  assign alarm_irq = status;
  assign wake_req  = pending;

endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
(
  input logic clk,
  input logic rst_ns,
  input logic tick_1hz,
  input logic busy,
  input logic load_time,
  input cal_t tm_live,
  input logic alarm_irq,
  input logic wake_req,
  input logic en_al,
  input logic oneshot,
  input logic match_evt
);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && $past(busy)) |=> !busy);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!tick_1hz && !load_time) |=> $stable(tm_live));

  p_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (tick_1hz && !load_time && tm_live.sc < 6'd60) |=> (tm_live.sc < 6'd60));

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(alarm_irq) |-> ($past(match_evt) && $past(en_al)));

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(alarm_irq) |-> wake_req);

  p_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(alarm_irq) && $past(oneshot)) |-> !en_al);

endmodule

bind cal_rtc cal_rtc_chk u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .tick_1hz  (tick_1hz),
  .busy      (busy),
  .load_time (load_time),
  .tm_live   (tm_live),
  .alarm_irq (alarm_irq),
  .wake_req  (wake_req),
  .en_al     (en_al),
  .oneshot   (oneshot),
  .match_evt (match_evt)
);

// File: tb/cal_rtc_tb_top.sv
module cal_rtc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_1hz;
  logic        bus_sel;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        alarm_irq;
  logic        wake_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cal_rtc dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .alarm_irq (alarm_irq),
    .wake_req  (wake_req)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) check(bus_rdata, 16'hDEAD, "scoreboard underflow");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic pin(input logic act_bit, input logic e, input string tag);
    @(negedge clk);
    check({15'b0, act_bit}, {15'b0, e}, tag);
  endtask

  task automatic commit();
    wr(6'h3C, 16'h0001);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic tick();
    @(posedge clk); #1; tick_1hz = 1'b1;
    @(posedge clk); #1; tick_1hz = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic set_blk(input logic [5:0] base, input int sc, input int mn, input int hr,
                         input int dm, input int dw, input int mo, input int yr);
    wr(base + 6'd0,  16'(sc));
    wr(base + 6'd2,  16'(mn));
    wr(base + 6'd4,  16'(hr));
    wr(base + 6'd6,  16'(dm));
    wr(base + 6'd8,  16'(dw));
    wr(base + 6'd10, 16'(mo));
    wr(base + 6'd12, 16'(yr));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_1hz = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(6'h00, 16'h0000, "R1 ctrl");
    rd(6'h02, 16'h0000, "R1 status");
    rd(6'h04, 16'h0000, "R1 enable");
    rd(6'h0A, 16'd0,    "R1 sec");
    rd(6'h10, 16'd1,    "R1 dom");
    rd(6'h12, 16'd1,    "R1 dow");
    rd(6'h14, 16'd1,    "R1 month");
    rd(6'h16, 16'd0,    "R1 year");
    rd(6'h18, 16'd0,    "R1 alarm sec");
    pin(alarm_irq, 1'b0, "R1 irq");
    pin(wake_req,  1'b0, "R1 wake");

    // R2 staged write invisible, R3 busy window and apply
    wr(6'h0A, 16'd30);
    rd(6'h0A, 16'd0, "R2 staged sec hidden");
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h3C; bus_wdata = 16'h0001;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 6'h00;
    exp_q.push_back(16'h0040); tag_q.push_back("R3 busy cycle 1");
    @(posedge clk); #1;
    exp_q.push_back(16'h0040); tag_q.push_back("R3 busy cycle 2");
    @(posedge clk); #1;
    exp_q.push_back(16'h0000); tag_q.push_back("R3 busy cleared");
    @(posedge clk); #1;
    bus_sel = 1'b0;
    rd(6'h0A, 16'd30, "R3 sec applied");

    // R5/R6 year-end rollover
    set_blk(6'h0A, 59, 59, 23, 31, 7, 12, 55);
    commit();
    tick();
    rd(6'h0A, 16'd0,  "R5 sec wrap");
    rd(6'h0C, 16'd0,  "R5 min wrap");
    rd(6'h0E, 16'd0,  "R5 hour wrap");
    rd(6'h12, 16'd1,  "R5 dow wrap");
    rd(6'h10, 16'd1,  "R6 dom wrap");
    rd(6'h14, 16'd1,  "R6 month wrap");
    rd(6'h16, 16'd56, "R6 year carry");

    // R6 leap February
    set_blk(6'h0A, 59, 59, 23, 28, 3, 2, 56);
    commit();
    tick();
    rd(6'h10, 16'd29, "R6 leap feb 29");
    rd(6'h14, 16'd2,  "R6 leap month held");

    // R6 common February
    set_blk(6'h0A, 59, 59, 23, 28, 3, 2, 57);
    commit();
    tick();
    rd(6'h10, 16'd1, "R6 common feb rollover dom");
    rd(6'h14, 16'd3, "R6 common feb rollover month");

    // R4 alarm-only commit keeps time
    wr(6'h18, 16'd33);
    commit();
    rd(6'h0E, 16'd0,  "R4 hour kept");
    rd(6'h10, 16'd1,  "R4 dom kept");
    rd(6'h18, 16'd33, "R4 alarm applied");

    // R7/R8 continuous alarm, weekday masked
    set_blk(6'h0A, 5, 0, 12, 10, 2, 3, 56);
    set_blk(6'h18, 6, 0, 12, 10, 5, 3, 56);
    wr(6'h08, 16'h0010);
    wr(6'h04, 16'h0001);
    commit();
    rd(6'h02, 16'h0000, "R7 no match yet");
    tick();
    pin(alarm_irq, 1'b1, "R8 irq high");
    pin(wake_req,  1'b1, "R11 wake follows pending");
    rd(6'h2E, 16'h0010, "R7 pending set");
    rd(6'h04, 16'h0001, "R7 enable kept");
    rd(6'h02, 16'h0001, "R8 status set");
    pin(alarm_irq, 1'b0, "R8 irq cleared by read");
    rd(6'h02, 16'h0000, "R8 status cleared");

    // R9 one-shot
    wr(6'h04, 16'h0005);
    wr(6'h18, 16'd7);
    commit();
    tick();
    rd(6'h04, 16'h0004, "R9 enable disarmed");
    rd(6'h02, 16'h0001, "R9 status set");

    // R11 pending clear
    wr(6'h2E, 16'h0000);
    rd(6'h2E, 16'h0000, "R11 pending cleared");
    pin(wake_req, 1'b0, "R11 wake low");

    // R10 disabled alarm
    wr(6'h18, 16'd8);
    commit();
    tick();
    rd(6'h02, 16'h0000, "R10 no status");
    rd(6'h2E, 16'h0000, "R10 no pending");
    pin(alarm_irq, 1'b0, "R10 irq low");

    // R7 weekday compared when unmasked
    wr(6'h04, 16'h0001);
    wr(6'h08, 16'h0000);
    wr(6'h18, 16'd9);
    commit();
    tick();
    rd(6'h0A, 16'd9,    "R7 time reached alarm second");
    rd(6'h02, 16'h0000, "R7 weekday mismatch blocks");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule